// File: doc/BRIEF.md
# Serial Power-Event Packet Transmitter

This block gathers CPU activity events into an 8-bit sticky packet. At a programmable interval it sends that packet over one wire to a companion power-management device. Each event strobe has an enable bit, and an enabled strobe sets its packet bit until the packet is sent. Packet bit 1 does not take a strobe. It is set instead by a memory access whose address falls inside a window described by a base and a mask.

The serial line idles low while an interval timer counts. When the timer runs out, the current packet is handed to the transmitter and the packet register is cleared. The line then carries a frame: two high clocks as a start mark, eight data bits with the most significant first, and one high clock as an end mark. After the end mark the line returns low. A 2-bit select chooses one of four interval lengths, each a module parameter given in clock cycles.

Top module: `pm_event_serializer`

## Requirements
- R1: While reset is held and afterwards until the first start mark, ser_out is low, and the first frame after reset carries 0x00 when no event was enabled.
- R2: Between an end mark and the next start mark, ser_out stays low for exactly INTV_0, INTV_1, INTV_2 or INTV_3 cycles, for intv_sel codes 0, 1, 2 and 3 respectively.
- R3: intv_sel is loaded into the timer while a frame is in progress, with the last load in the end-mark cycle. A change made during a low gap leaves that gap's length as it was and sets the length of the following gap.
- R4: Each frame starts with ser_out high for exactly two consecutive cycles.
- R5: The two start cycles are followed by the 8 packet bits, one per cycle, bit 7 first and bit 0 last.
- R6: After bit 0, ser_out is high for exactly one cycle and then low.
- R7: For any bit i other than 1, evt_stb[i] high at a clock edge while evt_en[i] is high sets packet bit i, and the bit stays set until it is sent.
- R8: A strobe whose evt_en bit is low has no effect on the packet.
- R9: evt_stb[1] is ignored. Packet bit 1 is set by a cycle with mem_valid high, evt_en[1] high and ((mem_addr ^ range_base) & range_mask) == 0, so a zero mask matches every address.
- R10: A packet is cleared when it is handed to the transmitter, and the next frame carries only events recorded after the hand-over.
- R11: An event recorded while a frame is being sent is not lost. It appears in the following frame.
- R12: With mem_valid low, no address sets packet bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stb | input | PKT_W | Per-event strobes, one bit per packet bit (bit 1 unused) |
| evt_en | input | PKT_W | Per-bit record enables |
| intv_sel | input | 2 | Interval code selecting INTV_0..INTV_3 |
| mem_valid | input | 1 | Memory access present this cycle |
| mem_addr | input | AW | Address of the memory access |
| range_base | input | AW | Window base address |
| range_mask | input | AW | Window compare mask (1 = bit compared) |
| ser_out | output | 1 | Registered serial frame output, idles low |

## Verification
A strobe or address match held for one clock is in the packet one edge later. It is sent if it arrives at least one edge before the edge that ends the low gap. The frame's first start cycle follows that edge by one cycle, the data begin three cycles after it, and the end mark comes eleven cycles after it. The bench applies each stimulus in the second cycle of a gap whose length is at least three, for exactly one edge, and decodes every frame from ser_out sampled at falling edges. A stimulus given in one gap is therefore always checked in the very next frame. An interval change is checked over two gaps: the gap it was made in keeps the old length and the gap after it takes the new one.

// File: rtl/pm_ser_pkg.sv
package pm_ser_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_t;
endpackage

// File: rtl/pm_interval_timer.sv
module pm_interval_timer #(
  parameter int INTV_0 = 40,
  parameter int INTV_1 = 100,
  parameter int INTV_2 = 200,
  parameter int INTV_3 = 330,
  parameter int CNT_W  = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       run,
  output logic       expire
);
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (sel)
      2'd0:    limit = CNT_W'(INTV_0 - 1);
      2'd1:    limit = CNT_W'(INTV_1 - 1);
      2'd2:    limit = CNT_W'(INTV_2 - 1);
      default: limit = CNT_W'(INTV_3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= limit;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0);

  // R2
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !expire) |=> run);
endmodule

// File: rtl/pm_range_match.sv
module pm_range_match #(
  parameter int AW = 32
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  output logic          hit
);
  logic [AW-1:0] diff;

  always_comb begin
    diff = (addr ^ base) & mask;
    hit  = valid && (diff == '0);
  end

  // R12
  always_comb begin
    if (!valid) no_valid_no_hit_chk: assert (!hit);
  end
endmodule

// File: rtl/pm_event_accum.sv
module pm_event_accum #(
  parameter int W         = 8,
  parameter int RANGE_BIT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stb,
  input  logic [W-1:0] en,
  input  logic         range_hit,
  input  logic         capture,
  output logic [W-1:0] pkt
);
  logic [W-1:0] raw;
  logic [W-1:0] set_vec;
  logic [W-1:0] pkt_q;

  for (genvar i = 0; i < W; i++) begin : g_src
    if (i == RANGE_BIT) begin : g_range
      assign raw[i] = range_hit;
    end else begin : g_strobe
      assign raw[i] = stb[i];
    end
  end

  assign set_vec = raw & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_q <= '0;
    end else begin
      pkt_q <= (capture ? '0 : pkt_q) | set_vec;
    end
  end

  assign pkt = pkt_q;

  // R8
  no_disabled_set_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ((pkt_q & ~$past(pkt_q) & ~$past(en)) == '0));
  // R10
  capture_clear_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> ((pkt_q & ~$past(raw)) == '0));
  // R11
  late_event_kept_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> ((pkt_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/pm_frame_shifter.sv
module pm_frame_shifter
  import pm_ser_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         expire,
  input  logic [W-1:0] pkt_in,
  output logic         capture,
  output logic         idle,
  output logic         ser_out
);
  localparam int BW = (W > 2) ? $clog2(W) : 1;

  tx_state_t      state;
  logic           hold;
  logic [BW-1:0]  bitcnt;
  logic [W-1:0]   shreg;
  logic           ser_q;

  assign idle    = (state == TX_IDLE);
  assign capture = idle && expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TX_IDLE;
      hold   <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
      ser_q  <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          ser_q <= 1'b0;
          if (expire) begin
            state <= TX_START;
            ser_q <= 1'b1;
            shreg <= pkt_in;
            hold  <= 1'b0;
          end
        end
        TX_START: begin
          if (!hold) begin
            hold  <= 1'b1;
            ser_q <= 1'b1;
          end else begin
            state  <= TX_DATA;
            ser_q  <= shreg[W-1];
            shreg  <= {shreg[W-2:0], 1'b0};
            bitcnt <= '0;
          end
        end
        TX_DATA: begin
          if (bitcnt == BW'(W - 1)) begin
            state <= TX_STOP;
            ser_q <= 1'b1;
          end else begin
            ser_q  <= shreg[W-1];
            shreg  <= {shreg[W-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end
        end
        default: begin
          state <= TX_IDLE;
          ser_q <= 1'b0;
        end
      endcase
    end
  end

  assign ser_out = ser_q;

  // R4
  start_pair_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> ser_out ##1 ser_out);
  // R5
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> ##2 (ser_out == $past(pkt_in[W-1], 3)));
  // R6
  end_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_STOP) |-> ser_out ##1 !ser_out);
  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE) |-> !ser_out);
endmodule

// File: rtl/pm_event_serializer.sv
module pm_event_serializer #(
  parameter int PKT_W     = 8,
  parameter int RANGE_BIT = 1,
  parameter int AW        = 32,
  parameter int INTV_0    = 40,
  parameter int INTV_1    = 100,
  parameter int INTV_2    = 200,
  parameter int INTV_3    = 330
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PKT_W-1:0] evt_stb,
  input  logic [PKT_W-1:0] evt_en,
  input  logic [1:0]       intv_sel,
  input  logic             mem_valid,
  input  logic [AW-1:0]    mem_addr,
  input  logic [AW-1:0]    range_base,
  input  logic [AW-1:0]    range_mask,
  output logic             ser_out
);
  localparam int M01      = (INTV_0 > INTV_1) ? INTV_0 : INTV_1;
  localparam int M23      = (INTV_2 > INTV_3) ? INTV_2 : INTV_3;
  localparam int INTV_MAX = (M01 > M23) ? M01 : M23;
  localparam int CNT_W    = $clog2(INTV_MAX + 1);

  logic             expire;
  logic             capture;
  logic             idle;
  logic             range_hit;
  logic [PKT_W-1:0] pkt;

  pm_interval_timer #(
    .INTV_0(INTV_0), .INTV_1(INTV_1), .INTV_2(INTV_2), .INTV_3(INTV_3),
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .sel   (intv_sel),
    .run   (idle),
    .expire(expire)
  );

  pm_range_match #(.AW(AW)) u_match (
    .valid(mem_valid),
    .addr (mem_addr),
    .base (range_base),
    .mask (range_mask),
    .hit  (range_hit)
  );

  pm_event_accum #(.W(PKT_W), .RANGE_BIT(RANGE_BIT)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .stb      (evt_stb),
    .en       (evt_en),
    .range_hit(range_hit),
    .capture  (capture),
    .pkt      (pkt)
  );

  pm_frame_shifter #(.W(PKT_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .expire (expire),
    .pkt_in (pkt),
    .capture(capture),
    .idle   (idle),
    .ser_out(ser_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !ser_out);
endmodule

// File: tb/pm_event_serializer_bench.sv
module pm_event_serializer_bench;
  localparam int W   = 8;
  localparam int AW  = 16;
  localparam int IV0 = 3;
  localparam int IV1 = 4;
  localparam int IV2 = 6;
  localparam int IV3 = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  evt_stb = '0;
  logic [W-1:0]  evt_en = '0;
  logic [1:0]    intv_sel = 2'd0;
  logic          mem_valid = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [AW-1:0] range_base = '0;
  logic [AW-1:0] range_mask = '0;
  logic          ser_out;

  always #2 clk = ~clk;

  pm_event_serializer #(
    .PKT_W(W), .RANGE_BIT(1), .AW(AW),
    .INTV_0(IV0), .INTV_1(IV1), .INTV_2(IV2), .INTV_3(IV3)
  ) u_pm_event_serializer (
    .clk(clk), .rst(rst), .evt_stb(evt_stb), .evt_en(evt_en),
    .intv_sel(intv_sel), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .range_base(range_base), .range_mask(range_mask), .ser_out(ser_out)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  function automatic void chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  function automatic int gap_for(int s);
    case (s)
      0: return IV0;
      1: return IV1;
      2: return IV2;
      default: return IV3;
    endcase
  endfunction

  // frame decoder on the serial line
  int         mst = 0;
  int         lowrun = 0;
  int         bidx = 0;
  int         frames = 0;
  int         cur_gap = 0;
  int         last_gap = 0;
  logic [7:0] cur = '0;
  logic [7:0] last_pkt = '0;

  always @(negedge clk) begin
    if (rst) begin
      mst = 0;
      lowrun = 0;
    end else begin
      case (mst)
        0: begin
          if (ser_out) begin
            cur_gap = lowrun;
            mst = 1;
          end else begin
            lowrun++;
          end
        end
        1: begin
          chk(ser_out == 1'b1, "R4 second start cycle", int'(ser_out), 1);
          mst = 2;
          bidx = W - 1;
        end
        2: begin
          cur[bidx] = ser_out;
          if (bidx == 0) mst = 3;
          else bidx--;
        end
        3: begin
          chk(ser_out == 1'b1, "R6 end mark", int'(ser_out), 1);
          mst = 4;
        end
        default: begin
          chk(ser_out == 1'b0, "R6 low after end mark", int'(ser_out), 0);
          last_pkt = cur;
          last_gap = cur_gap;
          frames++;
          lowrun = 1;
          mst = 0;
        end
      endcase
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic wait_frame();
    int f;
    f = frames;
    while (frames == f) @(posedge clk);
  endtask

  // called just after a frame was decoded; stimulus lasts one edge
  task automatic send(input logic [W-1:0] stb, input logic [W-1:0] en,
                      input logic mv, input logic [AW-1:0] a,
                      input logic [AW-1:0] b, input logic [AW-1:0] m);
    @(negedge clk);
    evt_stb = stb; evt_en = en; mem_valid = mv;
    mem_addr = a; range_base = b; range_mask = m;
    @(negedge clk);
    evt_stb = '0; mem_valid = 1'b0;
    wait_frame();
  endtask

  initial begin
    logic [W-1:0] exp;
    repeat (5) @(negedge clk);
    // R1 line low during reset
    chk(ser_out == 1'b0, "R1 low in reset", int'(ser_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_out == 1'b0, "R1 low after reset", int'(ser_out), 0);
    wait_frame();
    chk(last_pkt == 8'h00, "R1 first frame empty", int'(last_pkt), 0);

    // R5 R7 R8 exhaustive enable sweep, all strobes
    for (int e = 0; e < 256; e++) begin
      send(8'hFF, W'(e), 1'b0, '0, '0, '0);
      exp = W'(e) & 8'hFD;
      chk(last_pkt == exp, "R5 R7 R8 enable sweep", int'(last_pkt), int'(exp));
      chk(last_gap == IV0, "R2 gap code 0", last_gap, IV0);
    end

    // R9 single strobes; strobe 1 ignored
    for (int i = 0; i < W; i++) begin
      send(W'(1 << i), 8'hFF, 1'b0, '0, '0, '0);
      exp = (i == 1) ? 8'h00 : W'(1 << i);
      chk(last_pkt == exp, "R7 R9 single strobe", int'(last_pkt), int'(exp));
    end

    // R9 address window
    send('0, 8'hFF, 1'b1, 16'h12AB, 16'h1200, 16'hFF00);
    chk(last_pkt == 8'h02, "R9 inside window", int'(last_pkt), 2);
    send('0, 8'hFF, 1'b1, 16'h13AB, 16'h1200, 16'hFF00);
    chk(last_pkt == 8'h00, "R9 outside window", int'(last_pkt), 0);
    send('0, 8'hFF, 1'b1, 16'hBEEF, 16'h0000, 16'h0000);
    chk(last_pkt == 8'h02, "R9 zero mask matches", int'(last_pkt), 2);
    send('0, 8'hFD, 1'b1, 16'hBEEF, 16'h0000, 16'h0000);
    chk(last_pkt == 8'h00, "R9 bit1 disabled", int'(last_pkt), 0);
    send('0, 8'hFF, 1'b0, 16'h12AB, 16'h1200, 16'hFF00);
    chk(last_pkt == 8'h00, "R12 no valid no hit", int'(last_pkt), 0);
    for (int k = 0; k < AW; k++) begin
      logic [AW-1:0] mk;
      mk = 16'h5555;
      send('0, 8'hFF, 1'b1, 16'hA5A5 ^ AW'(1 << k), 16'hA5A5, mk);
      exp = mk[k] ? 8'h00 : 8'h02;
      chk(last_pkt == exp, "R9 mask bit sweep", int'(last_pkt), int'(exp));
    end

    // R10 cleared after send
    send(8'h5D, 8'hFF, 1'b0, '0, '0, '0);
    chk(last_pkt == 8'h5D, "R10 loaded frame", int'(last_pkt), 'h5D);
    send('0, 8'hFF, 1'b0, '0, '0, '0);
    chk(last_pkt == 8'h00, "R10 cleared after send", int'(last_pkt), 0);

    // R11 event during a frame is held over
    @(negedge clk);
    evt_stb = 8'h01; evt_en = 8'hFF;
    @(negedge clk);
    evt_stb = '0;
    while (mst != 2) @(posedge clk);
    @(negedge clk);
    evt_stb = 8'h80;
    @(negedge clk);
    evt_stb = '0;
    wait_frame();
    chk(last_pkt == 8'h01, "R11 current frame", int'(last_pkt), 1);
    send('0, 8'hFF, 1'b0, '0, '0, '0);
    chk(last_pkt == 8'h80, "R11 held event", int'(last_pkt), 'h80);

    // R3 interval change applies to the following gap
    for (int s = 1; s < 4; s++) begin
      int old_s;
      old_s = int'(intv_sel);
      @(negedge clk);
      intv_sel = 2'(s);
      wait_frame();
      chk(last_gap == gap_for(old_s), "R3 current gap keeps old code",
          last_gap, gap_for(old_s));
      send(8'hA4, 8'hFF, 1'b0, '0, '0, '0);
      chk(last_gap == gap_for(s), "R2 R3 new gap length", last_gap, gap_for(s));
      chk(last_pkt == 8'hA4, "R5 data at new interval", int'(last_pkt), 'hA4);
    end

    summary();
    $finish;
  end
endmodule